// File: doc/BRIEF.md
# Shared Local RAM Access Guard

This block decides, request by request, whether a main CPU or a coprocessor may touch a local RAM bank whose role is set by a two-bit configuration input. The bank can be owned outright by the CPU, lent to the coprocessor as data storage, or lent to it as instruction storage. In each role the block lets some access types through and refuses the others. A refused write never reaches the memory, and a refused read returns zero.

The grant decision is purely combinational, so each request is answered in the cycle it is presented. Requests are plain level signals with no back-pressure: the block never stalls a requester, and it only grants or refuses. Every refusal counts as a non-master violation. Three sticky flags record these violations: CPU read, CPU write and coprocessor. Each flag holds the address of its first violation until software clears the flag by writing 1. A debug qualifier lifts every restriction for the cycle in which it is high.

Top module: `lsram_access_guard`

## Requirements
- R1: Mode encoding on `cfg_mode`: 00 = CPU-dedicated, 01 = coprocessor data RAM, 10 = coprocessor program RAM, 11 = treated exactly as 00. In modes 00, 01 and 11, CPU reads and writes are granted.
- R2: In mode 10, both CPU reads and CPU writes are refused.
- R3: In mode 10, coprocessor data reads and writes are refused and coprocessor fetches are granted.
- R4: In modes 00 and 11, every coprocessor request (data read, data write, fetch) is refused.
- R5: In mode 01, coprocessor data reads and writes are granted and coprocessor fetches are refused.
- R6: While `dbg_qual` is high, every request in that cycle is granted and no violation flag is set.
- R7: A granted read returns the memory data in the same cycle. A refused read returns zero. A refused write leaves its grant (memory write enable) low.
- R8: A refused request sets its flag at the next clock edge. The flag bits are: bit0 = CPU read, bit1 = CPU write, bit2 = coprocessor. The address of the first violation is captured. Later violations do not change that address while the flag stays set.
- R9: Writing 1 to a bit of `viol_clr` clears that flag at the next edge. If a new violation arrives in the same cycle, the flag stays set and the new address is captured.
- R10: The coprocessor violation address is the fetch address when the fetch is refused, and the data address otherwise.
- R11: After reset all flags and captured addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Role of the RAM bank |
| dbg_qual | input | 1 | Debug access qualifier |
| cpu_rd_req | input | 1 | CPU read request |
| cpu_wr_req | input | 1 | CPU write request |
| cpu_addr | input | AW | CPU address |
| cpu_mem_rdata | input | DW | Memory data on the CPU read port |
| cpu_rd_gnt | output | 1 | CPU read granted |
| cpu_wr_gnt | output | 1 | CPU write granted (memory write enable) |
| cpu_rdata | output | DW | Read data returned to the CPU |
| cop_rd_req | input | 1 | Coprocessor data read request |
| cop_wr_req | input | 1 | Coprocessor data write request |
| cop_addr | input | AW | Coprocessor data address |
| cop_fetch_req | input | 1 | Coprocessor instruction fetch request |
| cop_fetch_addr | input | AW | Coprocessor fetch address |
| cop_mem_rdata | input | DW | Memory data on the coprocessor port |
| cop_rd_gnt | output | 1 | Coprocessor data read granted |
| cop_wr_gnt | output | 1 | Coprocessor data write granted |
| cop_fetch_gnt | output | 1 | Coprocessor fetch granted |
| cop_rdata | output | DW | Read or fetch data returned to the coprocessor |
| viol_clr | input | 3 | Write-1-to-clear strobes for the flags |
| viol_flags | output | 3 | Sticky violation flags |
| viol_addr_cpu_rd | output | AW | Captured CPU read violation address |
| viol_addr_cpu_wr | output | AW | Captured CPU write violation address |
| viol_addr_cop | output | AW | Captured coprocessor violation address |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in the same cycle as a fresh violation. The flag must then stay set while the captured address moves to the new request. The bench first raises a flag, then applies a clear together with a new refused request at a different address, and checks both the flag and the address. A similar case is the first-address hold: two back-to-back refusals at different addresses, where the second must leave the first address in place.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  typedef enum logic [1:0] {
    ROLE_CPU_OWN  = 2'b00,
    ROLE_COP_DATA = 2'b01,
    ROLE_COP_PROG = 2'b10,
    ROLE_RSVD     = 2'b11
  } ram_role_e;

  localparam int unsigned N_VIOL    = 3;
  localparam int unsigned VIOL_CPUR = 0;
  localparam int unsigned VIOL_CPUW = 1;
  localparam int unsigned VIOL_COP  = 2;
endpackage

// File: rtl/lsram_perm_dec.sv
module lsram_perm_dec
  import lsram_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dbg,
  output logic       allow_cpu,
  output logic       allow_cop_data,
  output logic       allow_fetch
);
  ram_role_e role;
  assign role = ram_role_e'(mode);

  always_comb begin
    allow_cpu      = 1'b0;
    allow_cop_data = 1'b0;
    allow_fetch    = 1'b0;
    unique case (role)
      ROLE_COP_DATA: begin
        allow_cpu      = 1'b1;
        allow_cop_data = 1'b1;
      end
      ROLE_COP_PROG: allow_fetch = 1'b1;
      default:       allow_cpu   = 1'b1;
    endcase
    if (dbg) begin
      allow_cpu      = 1'b1;
      allow_cop_data = 1'b1;
      allow_fetch    = 1'b1;
    end
  end
endmodule

// File: rtl/lsram_viol_rec.sv
module lsram_viol_rec #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          clr,
  output logic          flag,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else begin
      if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (set && (!flag || clr)) addr <= set_addr;
    end
  end

  AST_FLAG_SETS:   assert property (@(posedge clk) disable iff (!rst_n) set |=> flag);                          // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr) |=> flag);               // R8
  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr) |=> $stable(addr));      // R8
  AST_CLR_WORKS:   assert property (@(posedge clk) disable iff (!rst_n) (clr && !set) |=> !flag);               // R9
endmodule

// File: rtl/lsram_access_guard.sv
module lsram_access_guard
  import lsram_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic          dbg_qual,
  input  logic          cpu_rd_req,
  input  logic          cpu_wr_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_mem_rdata,
  output logic          cpu_rd_gnt,
  output logic          cpu_wr_gnt,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cop_rd_req,
  input  logic          cop_wr_req,
  input  logic [AW-1:0] cop_addr,
  input  logic          cop_fetch_req,
  input  logic [AW-1:0] cop_fetch_addr,
  input  logic [DW-1:0] cop_mem_rdata,
  output logic          cop_rd_gnt,
  output logic          cop_wr_gnt,
  output logic          cop_fetch_gnt,
  output logic [DW-1:0] cop_rdata,
  input  logic [2:0]    viol_clr,
  output logic [2:0]    viol_flags,
  output logic [AW-1:0] viol_addr_cpu_rd,
  output logic [AW-1:0] viol_addr_cpu_wr,
  output logic [AW-1:0] viol_addr_cop
);
  logic allow_cpu, allow_cop_data, allow_fetch;

  lsram_perm_dec u_dec (
    .mode           (cfg_mode),
    .dbg            (dbg_qual),
    .allow_cpu      (allow_cpu),
    .allow_cop_data (allow_cop_data),
    .allow_fetch    (allow_fetch)
  );

  assign cpu_rd_gnt    = cpu_rd_req    & allow_cpu;
  assign cpu_wr_gnt    = cpu_wr_req    & allow_cpu;
  assign cop_rd_gnt    = cop_rd_req    & allow_cop_data;
  assign cop_wr_gnt    = cop_wr_req    & allow_cop_data;
  assign cop_fetch_gnt = cop_fetch_req & allow_fetch;

  assign cpu_rdata = cpu_rd_gnt ? cpu_mem_rdata : '0;
  assign cop_rdata = (cop_rd_gnt || cop_fetch_gnt) ? cop_mem_rdata : '0;

  logic          fetch_blk, data_blk;
  logic [N_VIOL-1:0]         v_set;
  logic [N_VIOL-1:0][AW-1:0] v_addr_in, v_addr_out;

  assign fetch_blk = cop_fetch_req & ~allow_fetch;
  assign data_blk  = (cop_rd_req | cop_wr_req) & ~allow_cop_data;

  assign v_set[VIOL_CPUR]     = cpu_rd_req & ~allow_cpu;
  assign v_set[VIOL_CPUW]     = cpu_wr_req & ~allow_cpu;
  assign v_set[VIOL_COP]      = fetch_blk | data_blk;
  assign v_addr_in[VIOL_CPUR] = cpu_addr;
  assign v_addr_in[VIOL_CPUW] = cpu_addr;
  assign v_addr_in[VIOL_COP]  = fetch_blk ? cop_fetch_addr : cop_addr;

  for (genvar g = 0; g < N_VIOL; g++) begin : g_rec
    lsram_viol_rec #(.AW(AW)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (v_set[g]),
      .set_addr (v_addr_in[g]),
      .clr      (viol_clr[g]),
      .flag     (viol_flags[g]),
      .addr     (v_addr_out[g])
    );
  end

  assign viol_addr_cpu_rd = v_addr_out[VIOL_CPUR];
  assign viol_addr_cpu_wr = v_addr_out[VIOL_CPUW];
  assign viol_addr_cop    = v_addr_out[VIOL_COP];

  AST_PROG_CPU_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b10 && !dbg_qual) |-> !(cpu_rd_gnt || cpu_wr_gnt));                         // R2
  AST_PROG_COP_DATA:  assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b10 && !dbg_qual) |-> !(cop_rd_gnt || cop_wr_gnt));                         // R3
  AST_OWN_COP_BLOCK:  assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[1] == cfg_mode[0] && !dbg_qual) |-> !(cop_rd_gnt || cop_wr_gnt || cop_fetch_gnt)); // R4
  AST_DBG_NO_FLAG:    assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_qual && viol_flags == 3'b000 && viol_clr == 3'b000) |=> viol_flags == 3'b000);        // R6
  AST_BLOCKED_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_gnt |-> cpu_rdata == '0);                                                          // R7
endmodule

// File: tb/tb_lsram_access_guard.sv
module tb_lsram_access_guard;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0;
  logic dbg_qual = 0;
  logic cpu_rd_req = 0, cpu_wr_req = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_mem_rdata = 32'hA5A5_1234;
  logic cpu_rd_gnt, cpu_wr_gnt;
  logic [DW-1:0] cpu_rdata;
  logic cop_rd_req = 0, cop_wr_req = 0, cop_fetch_req = 0;
  logic [AW-1:0] cop_addr = 0, cop_fetch_addr = 0;
  logic [DW-1:0] cop_mem_rdata = 32'h5A5A_9876;
  logic cop_rd_gnt, cop_wr_gnt, cop_fetch_gnt;
  logic [DW-1:0] cop_rdata;
  logic [2:0] viol_clr = 0;
  logic [2:0] viol_flags;
  logic [AW-1:0] viol_addr_cpu_rd, viol_addr_cpu_wr, viol_addr_cop;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsram_access_guard #(.AW(AW), .DW(DW)) dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rd_req = 0; cpu_wr_req = 0; cop_rd_req = 0; cop_wr_req = 0;
    cop_fetch_req = 0; dbg_qual = 0; viol_clr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); idle(); viol_clr = 3'b111;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    check("R11 flags", {29'd0, viol_flags}, 0);
    check("R11 addr cpu rd", {20'd0, viol_addr_cpu_rd}, 0);
    check("R11 addr cop", {20'd0, viol_addr_cop}, 0);
  endtask

  task automatic t_cpu_allowed();
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      @(negedge clk); idle(); cfg_mode = 2'(m);
      cpu_rd_req = 1; cpu_wr_req = 1; cpu_addr = 12'h010;
      #1;
      check("R1 cpu rd gnt", {31'd0, cpu_rd_gnt}, 1);
      check("R1 cpu wr gnt", {31'd0, cpu_wr_gnt}, 1);
      check("R7 cpu rdata pass", cpu_rdata, cpu_mem_rdata);
    end
    @(negedge clk); idle();
    check("R1 no flags", {29'd0, viol_flags}, 0);
  endtask

  task automatic t_prog_cpu();
    @(negedge clk); idle(); cfg_mode = 2'b10;
    cpu_rd_req = 1; cpu_wr_req = 1; cpu_addr = 12'h123;
    #1;
    check("R2 cpu rd blocked", {31'd0, cpu_rd_gnt}, 0);
    check("R7 cpu wr blocked", {31'd0, cpu_wr_gnt}, 0);
    check("R7 cpu rdata zero", cpu_rdata, 0);
    @(negedge clk); cpu_addr = 12'h456;
    check("R8 flags cpu", {29'd0, viol_flags}, 3'b011);
    check("R8 addr rd", {20'd0, viol_addr_cpu_rd}, 12'h123);
    check("R8 addr wr", {20'd0, viol_addr_cpu_wr}, 12'h123);
    @(negedge clk); idle();
    check("R8 first addr kept", {20'd0, viol_addr_cpu_rd}, 12'h123);
    viol_clr = 3'b001;
    @(negedge clk); idle();
    check("R9 clear rd only", {29'd0, viol_flags}, 3'b010);
    clear_all();
  endtask

  task automatic t_cop();
    @(negedge clk); idle(); cfg_mode = 2'b00;
    cop_rd_req = 1; cop_addr = 12'h200;
    #1;
    check("R4 cop rd blocked", {31'd0, cop_rd_gnt}, 0);
    check("R7 cop rdata zero", cop_rdata, 0);
    @(negedge clk); idle();
    check("R8 cop flag", {29'd0, viol_flags}, 3'b100);
    check("R8 cop addr", {20'd0, viol_addr_cop}, 12'h200);
    clear_all();
    cfg_mode = 2'b11; cop_fetch_req = 1; cop_fetch_addr = 12'h2F0;
    #1;
    check("R4 rsvd fetch blocked", {31'd0, cop_fetch_gnt}, 0);
    clear_all();
    cfg_mode = 2'b01; cop_rd_req = 1; cop_wr_req = 1; cop_addr = 12'h300;
    #1;
    check("R5 cop rd gnt", {31'd0, cop_rd_gnt}, 1);
    check("R5 cop wr gnt", {31'd0, cop_wr_gnt}, 1);
    check("R7 cop rdata pass", cop_rdata, cop_mem_rdata);
    cop_fetch_req = 1; cop_fetch_addr = 12'h3AA;
    #1;
    check("R5 fetch blocked", {31'd0, cop_fetch_gnt}, 0);
    @(negedge clk); idle();
    check("R10 fetch addr", {20'd0, viol_addr_cop}, 12'h3AA);
    clear_all();
    cfg_mode = 2'b10; cop_fetch_req = 1; cop_wr_req = 1; cop_addr = 12'h0C0;
    #1;
    check("R3 fetch gnt", {31'd0, cop_fetch_gnt}, 1);
    check("R3 cop wr blocked", {31'd0, cop_wr_gnt}, 0);
    @(negedge clk); idle();
    check("R10 data addr", {20'd0, viol_addr_cop}, 12'h0C0);
    clear_all();
  endtask

  task automatic t_dbg();
    @(negedge clk); idle(); cfg_mode = 2'b10; dbg_qual = 1;
    cpu_rd_req = 1; cpu_wr_req = 1; cop_rd_req = 1; cop_wr_req = 1;
    #1;
    check("R6 all granted", {27'd0, cpu_rd_gnt, cpu_wr_gnt, cop_rd_gnt, cop_wr_gnt, 1'b1}, 5'b11111);
    @(negedge clk); idle();
    check("R6 no flags", {29'd0, viol_flags}, 0);
  endtask

  task automatic t_clr_set();
    @(negedge clk); idle(); cfg_mode = 2'b10; cpu_wr_req = 1; cpu_addr = 12'h0AA;
    @(negedge clk); idle(); cfg_mode = 2'b10; cpu_wr_req = 1; cpu_addr = 12'h0BB; viol_clr = 3'b010;
    @(negedge clk); idle();
    check("R9 set wins", {29'd0, viol_flags}, 3'b010);
    check("R9 new addr", {20'd0, viol_addr_cpu_wr}, 12'h0BB);
    clear_all();
    check("R9 cleared", {29'd0, viol_flags}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cpu_allowed();
    t_prog_cpu();
    t_cop();
    t_dbg();
    t_clr_set();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule